// File: doc/BRIEF.md
# Reader Power-Mode Controller

This block sequences the power states of a contactless-reader digital core. The core can be running, held in hard power-down by an active-low pin, parked in soft power-down by a register bit, or waiting out the exit delay that follows a soft power-down. From the current state the controller drives the oscillator enable, the current-sink enable, input isolation and output freezing. It also drives the antenna-driver and receiver enables, and it supplies the value that software reads back for the soft power-down bit.

Soft power-down can end in three ways: software clears the bit, an RF field is detected while auto-wakeup is enabled, or the wake byte arrives over a UART host link. Each of these starts a fixed exit count, and the status bit keeps reading 1 until the count ends. After the count ends, the controller blocks host register accesses to any address other than 0. The block stays closed until a read of address 0 completes, so a host polling address 0 finds out when the core is usable again.

Top module: `rdr_pwr_ctrl`

## Requirements
- R1: One clock after `hpd_n` is sampled low, `osc_en`=0, `sink_en`=0, `in_iso`=1, `out_frz`=1, `ant_drv_en`=0 and `rx_en`=0.
- R2: While `hpd_n` stays low, the RF field, UART bytes and soft power-down writes have no effect, and the block stays in hard power-down.
- R3: After reset, or one clock after `hpd_n` returns high, the block is running: `pd_status`=0, `osc_en`=1, `sink_en`=1, `in_iso`=0, `out_frz`=0, and host accesses to any address pass.
- R4: When running, a soft power-down write (`sw_wr`=1, `sw_pd_val`=1) gives `pd_status`=1, `osc_en`=0 and `sink_en`=0 from the next clock, with `in_iso`=0 and `out_frz`=0.
- R5: A soft power-down write of 0 starts an exit lasting exactly EXIT_CYCLES (default 1024) clocks, during which `osc_en`=1, `sink_en`=0 and `pd_status`=1. On the clock after that, `pd_status`=0 and the block is running.
- R6: In soft power-down, `rf_field`=1 starts the same exit only when `autowake_en`=1. With `autowake_en`=0 the field has no effect.
- R7: In soft power-down, a UART strobe carrying byte 0x55 starts the exit only when `uart_sel`=1. Other byte values, or `uart_sel`=0, have no effect.
- R8: A soft power-down write of 1 during the exit count returns the block to soft power-down (`osc_en`=0).
- R9: After an exit completes, and until the access gate opens, a host access to a nonzero address gives `reg_we`=0 and `host_rdata`=0.
- R10: While the gate is closed, accesses to address 0 pass (`reg_we` follows a write, and `host_rdata` = `reg_rdata` on a read). A read of address 0 opens the gate from the next clock.
- R11: `ant_drv_en` = 1 only when the block is running and both `tx1_en` and `tx2_en` are 1. `rx_en` stays 1 while the block is running, whatever the transmitter bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpd_n | input | 1 | Hard power-down pin, active low |
| sw_wr | input | 1 | Strobe for a write to the soft power-down bit |
| sw_pd_val | input | 1 | Value written to the soft power-down bit |
| autowake_en | input | 1 | Allows an RF field to end soft power-down |
| rf_field | input | 1 | External RF field detected |
| uart_sel | input | 1 | Host link is a UART |
| uart_vld | input | 1 | UART byte received strobe |
| uart_byte | input | 8 | Received UART byte |
| tx1_en | input | 1 | Transmitter 1 enable bit |
| tx2_en | input | 1 | Transmitter 2 enable bit |
| host_req | input | 1 | Host register access request |
| host_we | input | 1 | Host access is a write |
| host_addr | input | AW (6) | Host register address |
| reg_rdata | input | DW (8) | Read data from the register file |
| osc_en | output | 1 | Oscillator enable |
| sink_en | output | 1 | Current-sink enable |
| in_iso | output | 1 | Isolate and clamp digital inputs |
| out_frz | output | 1 | Freeze output pins |
| pd_status | output | 1 | Readback of the soft power-down bit |
| ant_drv_en | output | 1 | Antenna driver enable |
| rx_en | output | 1 | Receiver enable |
| reg_we | output | 1 | Gated register write enable |
| host_rdata | output | DW (8) | Gated read data returned to the host |

## Verification
The bench samples `pd_status` on the exact clock where the exit count ends. A counter that is off by one would show the bit clearing one clock early or one clock late. It checks that a field without auto-wakeup, a wrong UART byte, and a correct byte with the UART not selected all leave the oscillator off; a decoder that is too permissive would wake early. It checks that wake sources and writes are ignored while the pin is held low, so a design that leaks inputs through isolation would leave hard power-down. A randomized access phase follows each exit and models the address-0 gate. A gate that opens on a write, opens on the wrong clock, or leaks read data would give data or write enables at nonzero addresses.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_SOFT = 2'd1,
        PM_EXIT = 2'd2,
        PM_HARD = 2'd3
    } pm_state_e;

    localparam logic [7:0] WAKE_BYTE = 8'h55;
endpackage

// File: rtl/rpc_wake_src.sv
module rpc_wake_src
    import rpc_pkg::*;
(
    input  logic       autowake_en,
    input  logic       rf_field,
    input  logic       uart_sel,
    input  logic       uart_vld,
    input  logic [7:0] uart_byte,
    output logic       wake_req
);
    logic rf_wake;
    logic uart_wake;

    always_comb begin
        rf_wake   = autowake_en & rf_field;
        uart_wake = uart_sel & uart_vld & (uart_byte == WAKE_BYTE);
        wake_req  = rf_wake | uart_wake;
    end
endmodule

// File: rtl/rpc_access_gate.sv
module rpc_access_gate #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          force_open,
    input  logic          close_gate,
    input  logic          in_run,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] reg_rdata,
    output logic          reg_we,
    output logic [DW-1:0] host_rdata,
    output logic          gate_ready
);
    logic ready_d, ready_q;
    logic addr_zero;
    logic pass;

    always_comb begin
        addr_zero  = (host_addr == '0);
        pass       = in_run & host_req & (ready_q | addr_zero);
        reg_we     = pass & host_we;
        host_rdata = (pass & ~host_we) ? reg_rdata : '0;

        ready_d = ready_q;
        if (force_open) begin
            ready_d = 1'b1;
        end else if (close_gate) begin
            ready_d = 1'b0;
        end else if (in_run && host_req && !host_we && addr_zero) begin
            ready_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b1;
        end else begin
            ready_q <= ready_d;
        end
    end

    assign gate_ready = ready_q;
endmodule

// File: rtl/rdr_pwr_ctrl.sv
module rdr_pwr_ctrl
    import rpc_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 8,
    parameter int EXIT_CYCLES = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hpd_n,
    input  logic          sw_wr,
    input  logic          sw_pd_val,
    input  logic          autowake_en,
    input  logic          rf_field,
    input  logic          uart_sel,
    input  logic          uart_vld,
    input  logic [7:0]    uart_byte,
    input  logic          tx1_en,
    input  logic          tx2_en,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] reg_rdata,
    output logic          osc_en,
    output logic          sink_en,
    output logic          in_iso,
    output logic          out_frz,
    output logic          pd_status,
    output logic          ant_drv_en,
    output logic          rx_en,
    output logic          reg_we,
    output logic [DW-1:0] host_rdata
);
    localparam int CW = (EXIT_CYCLES > 2) ? $clog2(EXIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(EXIT_CYCLES - 1);

    typedef struct packed {
        pm_state_e     st;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wake_req;
    logic close_gate;
    logic gate_ready;
    logic in_run;
    logic [CW-1:0] exit_cnt;

    rpc_wake_src u_wake (
        .autowake_en (autowake_en),
        .rf_field    (rf_field),
        .uart_sel    (uart_sel),
        .uart_vld    (uart_vld),
        .uart_byte   (uart_byte),
        .wake_req    (wake_req)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.cnt = '0;
        if (!hpd_n) begin
            ctl_d.st = PM_HARD;
        end else begin
            unique case (ctl_q.st)
                PM_HARD: ctl_d.st = PM_RUN;
                PM_RUN: begin
                    if (sw_wr && sw_pd_val) ctl_d.st = PM_SOFT;
                end
                PM_SOFT: begin
                    if ((sw_wr && !sw_pd_val) || wake_req) ctl_d.st = PM_EXIT;
                end
                PM_EXIT: begin
                    if (sw_wr && sw_pd_val) begin
                        ctl_d.st = PM_SOFT;
                    end else if (ctl_q.cnt == LAST) begin
                        ctl_d.st = PM_RUN;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
                default: ctl_d.st = PM_HARD;
            endcase
        end
        close_gate = (ctl_q.st == PM_EXIT) && (ctl_d.st == PM_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: PM_RUN, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        in_run     = (ctl_q.st == PM_RUN);
        osc_en     = in_run || (ctl_q.st == PM_EXIT);
        sink_en    = in_run;
        in_iso     = (ctl_q.st == PM_HARD);
        out_frz    = (ctl_q.st == PM_HARD);
        pd_status  = (ctl_q.st == PM_SOFT) || (ctl_q.st == PM_EXIT);
        rx_en      = in_run;
        ant_drv_en = in_run && tx1_en && tx2_en;
        exit_cnt   = ctl_q.cnt;
    end

    rpc_access_gate #(.AW(AW), .DW(DW)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_open (ctl_q.st == PM_HARD),
        .close_gate (close_gate),
        .in_run     (in_run),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .reg_rdata  (reg_rdata),
        .reg_we     (reg_we),
        .host_rdata (host_rdata),
        .gate_ready (gate_ready)
    );
endmodule

// File: rtl/rdr_pwr_ctrl_chk.sv
module rdr_pwr_ctrl_chk #(
    parameter int AW = 6,
    parameter int DW = 8,
    parameter int CW = 10,
    parameter int EXIT_CYCLES = 1024
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hpd_n,
    input logic          sw_wr,
    input logic          sw_pd_val,
    input logic          tx1_en,
    input logic          tx2_en,
    input logic          host_req,
    input logic          host_we,
    input logic [AW-1:0] host_addr,
    input logic          osc_en,
    input logic          sink_en,
    input logic          in_iso,
    input logic          out_frz,
    input logic          pd_status,
    input logic          ant_drv_en,
    input logic          rx_en,
    input logic          reg_we,
    input logic [DW-1:0] host_rdata,
    input logic          gate_ready,
    input logic [CW-1:0] exit_cnt
);
    localparam logic [CW-1:0] LAST = CW'(EXIT_CYCLES - 1);

    assert_hard_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hpd_n |=> (!osc_en && !sink_en && in_iso && out_frz && !ant_drv_en && !rx_en));

    assert_hard_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_iso && !hpd_n) |=> in_iso);

    assert_soft_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hpd_n && sink_en && sw_wr && sw_pd_val) |=> (pd_status && !osc_en && !sink_en && !in_iso));

    assert_exit_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pd_status) && $past(hpd_n)) |-> ($past(exit_cnt) == LAST));

    assert_count_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_cnt != '0) |-> (pd_status && osc_en && !sink_en));

    assert_gate_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_ready && host_req && host_addr != '0) |-> (!reg_we && host_rdata == '0));

    assert_gate_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hpd_n && sink_en && host_req && !host_we && host_addr == '0) |=> gate_ready);

    assert_ant_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx1_en && tx2_en) |-> !ant_drv_en);

    assert_rx_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ant_drv_en |-> rx_en);
endmodule

bind rdr_pwr_ctrl rdr_pwr_ctrl_chk #(
    .AW(AW), .DW(DW), .CW(CW), .EXIT_CYCLES(EXIT_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hpd_n(hpd_n), .sw_wr(sw_wr), .sw_pd_val(sw_pd_val),
    .tx1_en(tx1_en), .tx2_en(tx2_en), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .osc_en(osc_en), .sink_en(sink_en), .in_iso(in_iso),
    .out_frz(out_frz), .pd_status(pd_status), .ant_drv_en(ant_drv_en), .rx_en(rx_en),
    .reg_we(reg_we), .host_rdata(host_rdata), .gate_ready(gate_ready), .exit_cnt(exit_cnt)
);

// File: tb/tb_rdr_pwr_ctrl.sv
module tb_rdr_pwr_ctrl;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int EXIT_CYCLES = 1024;

    logic clk = 1'b0;
    logic rst_n, hpd_n, sw_wr, sw_pd_val, autowake_en, rf_field, uart_sel, uart_vld;
    logic [7:0] uart_byte;
    logic tx1_en, tx2_en, host_req, host_we;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] reg_rdata;
    logic osc_en, sink_en, in_iso, out_frz, pd_status, ant_drv_en, rx_en, reg_we;
    logic [DW-1:0] host_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rdr_pwr_ctrl #(.AW(AW), .DW(DW), .EXIT_CYCLES(EXIT_CYCLES)) dut (
        .clk(clk), .rst_n(rst_n), .hpd_n(hpd_n), .sw_wr(sw_wr), .sw_pd_val(sw_pd_val),
        .autowake_en(autowake_en), .rf_field(rf_field), .uart_sel(uart_sel),
        .uart_vld(uart_vld), .uart_byte(uart_byte), .tx1_en(tx1_en), .tx2_en(tx2_en),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .reg_rdata(reg_rdata), .osc_en(osc_en), .sink_en(sink_en), .in_iso(in_iso),
        .out_frz(out_frz), .pd_status(pd_status), .ant_drv_en(ant_drv_en),
        .rx_en(rx_en), .reg_we(reg_we), .host_rdata(host_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_write(input logic v);
        sw_wr = 1'b1; sw_pd_val = v;
        tick(1);
        sw_wr = 1'b0; sw_pd_val = 1'b0;
    endtask

    function automatic logic [DW-1:0] exp_rdata(input logic rdy, input logic req,
        input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        return (req && !we && (rdy || a == '0)) ? d : '0;
    endfunction

    function automatic logic exp_we(input logic rdy, input logic req,
        input logic we, input logic [AW-1:0] a);
        return req && we && (rdy || a == '0);
    endfunction

    task automatic random_run(input int iters);
        logic m_ready = 1'b0;
        for (int i = 0; i < iters; i++) begin
            host_req  = $urandom_range(0, 3) != 0;
            host_we   = $urandom_range(0, 1) == 1;
            host_addr = ($urandom_range(0, 3) == 0) ? '0 : AW'($urandom_range(1, 63));
            reg_rdata = DW'($urandom);
            tx1_en    = $urandom_range(0, 1) == 1;
            tx2_en    = $urandom_range(0, 1) == 1;
            #1;
            check(m_ready ? "R10 random" : "R9 random", host_rdata,
                  exp_rdata(m_ready, host_req, host_we, host_addr, reg_rdata));
            check(m_ready ? "R10 random we" : "R9 random we", reg_we,
                  exp_we(m_ready, host_req, host_we, host_addr));
            check("R11 random", ant_drv_en, tx1_en & tx2_en);
            if (host_req && !host_we && host_addr == '0) m_ready = 1'b1;
            tick(1);
        end
        host_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; hpd_n = 1; sw_wr = 0; sw_pd_val = 0; autowake_en = 0; rf_field = 0;
        uart_sel = 0; uart_vld = 0; uart_byte = 0; tx1_en = 0; tx2_en = 0;
        host_req = 0; host_we = 0; host_addr = 0; reg_rdata = 0;
        tick(3);
        rst_n = 1;
        tick(1);

        // Reset state (R3)
        check("R3 pd_status", pd_status, 0);
        check("R3 osc_en", osc_en, 1);
        check("R3 sink_en", sink_en, 1);
        check("R3 iso/frz", {in_iso, out_frz}, 0);
        host_req = 1; host_addr = 7; reg_rdata = 8'h3C; #1;
        check("R3 gate open", host_rdata, 8'h3C);
        host_req = 0;

        // Transmitter bits (R11)
        tx1_en = 1; tx2_en = 1; #1;
        check("R11 both on", ant_drv_en, 1);
        tx2_en = 0; #1;
        check("R11 tx2 off", ant_drv_en, 0);
        check("R11 rx stays", rx_en, 1);
        tx2_en = 1;

        // Soft entry (R4)
        sw_write(1'b1);
        check("R4 pd_status", pd_status, 1);
        check("R4 osc/sink", {osc_en, sink_en}, 0);
        check("R4 iso/frz", {in_iso, out_frz}, 0);
        check("R11 ant off in soft", ant_drv_en, 0);

        // RF without / with auto-wakeup (R6), exit length (R5)
        rf_field = 1; tick(5);
        check("R6 no autowake", osc_en, 0);
        autowake_en = 1; tick(1);
        autowake_en = 0; rf_field = 0;
        check("R6 rf wake osc", osc_en, 1);
        check("R5 exit sink", sink_en, 0);
        tick(EXIT_CYCLES - 1);
        check("R5 still set at last exit clock", pd_status, 1);
        tick(1);
        check("R5 cleared after exit", pd_status, 0);
        check("R5 running", sink_en, 1);

        // Access gate (R9, R10)
        host_req = 1; host_we = 0; host_addr = 5; reg_rdata = 8'hA5; #1;
        check("R9 read blocked", host_rdata, 0);
        host_we = 1; #1;
        check("R9 write blocked", reg_we, 0);
        host_addr = 0; #1;
        check("R10 addr0 write passes", reg_we, 1);
        host_we = 0; #1;
        check("R10 addr0 read passes", host_rdata, 8'hA5);
        tick(1);
        host_addr = 5; #1;
        check("R10 gate opened", host_rdata, 8'hA5);
        host_req = 0;

        // UART wake (R7)
        sw_write(1'b1);
        uart_sel = 1; uart_vld = 1; uart_byte = 8'h54; tick(1);
        check("R7 wrong byte", osc_en, 0);
        uart_sel = 0; uart_byte = 8'h55; tick(1);
        check("R7 uart not selected", osc_en, 0);
        uart_sel = 1; tick(1);
        uart_vld = 0; uart_sel = 0;
        check("R7 wake byte osc", osc_en, 1);
        check("R7 wake byte status", pd_status, 1);

        // Re-entry during exit (R8)
        tick(10);
        sw_write(1'b1);
        check("R8 back to soft", osc_en, 0);
        sw_write(1'b0);
        tick(EXIT_CYCLES);
        check("R5 exit after restart", pd_status, 0);
        host_req = 1; host_we = 0; host_addr = 9; #1;
        check("R9 gate closed again", host_rdata, 0);
        host_req = 0;

        // Hard power-down (R1, R2, R3)
        sw_write(1'b1);
        hpd_n = 0; tick(1);
        check("R1 iso/frz", {in_iso, out_frz}, 2'b11);
        check("R1 osc/sink", {osc_en, sink_en}, 0);
        check("R1 rx/ant", {rx_en, ant_drv_en}, 0);
        autowake_en = 1; rf_field = 1; uart_sel = 1; uart_vld = 1; uart_byte = 8'h55;
        sw_wr = 1; sw_pd_val = 0;
        tick(3);
        check("R2 stays hard", {in_iso, osc_en}, 2'b10);
        autowake_en = 0; rf_field = 0; uart_sel = 0; uart_vld = 0; sw_wr = 0;
        hpd_n = 1; tick(1);
        check("R3 release iso", in_iso, 0);
        check("R3 release status", pd_status, 0);
        check("R3 release sink", sink_en, 1);
        host_req = 1; host_addr = 9; reg_rdata = 8'h66; #1;
        check("R3 release gate open", host_rdata, 8'h66);
        host_req = 0;

        // Random accesses after an exit (R9, R10, R11)
        sw_write(1'b1);
        sw_write(1'b0);
        tick(EXIT_CYCLES);
        check("R5 before random", pd_status, 0);
        random_run(400);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule